// File: doc/BRIEF.md
# ADC Conversion Control and Result Queue

This block sits between a 12-bit analog-to-digital converter and a host bus. It decides when a conversion starts and buffers the results until the host collects them. A conversion can be requested in three ways: a one-cycle software strobe, a high-to-low transition on a sample-timer output, or a high-to-low transition on an external active-low convert line. The block gives the converter a one-cycle start pulse. It then waits for the converter's done strobe and captures the 12-bit result.

Each result is widened to a 16-bit word when it is written into a first-in first-out queue. The widening is either sign extension or zero padding, chosen by a format input. The host collects each word with two byte reads, low byte first; the high-byte read removes the word. Three status outputs are provided: a data-available flag, a sticky flag for a result lost to a full queue, and a sticky flag for a start request that arrives during a conversion. An enable gates the two error flags onto an interrupt line. A clear strobe empties the queue, puts the most recent conversion result back in as its only entry, clears both error flags and abandons any conversion in flight.

All inputs are synchronous to `clk`. The queue depth must be a power of two.

Top module: `conv_fifo_ctrl`

## Requirements
- R1: A conversion is requested by `start_wr` high for a cycle, by `timer_out` going from 1 to 0, or by `ext_conv_n` going from 1 to 0. A 0-to-1 transition on either line requests nothing.
- R2: An accepted request makes `adc_start` high for exactly one cycle, on the clock edge that samples the request. The result on `adc_data` is captured on the edge where `adc_done` is high while the conversion is in progress.
- R3: The word is formed when it is stored. With `fmt_twos`=1 the stored word is bits [11:0] of the result with bit 11 copied into bits [15:12]. With `fmt_twos`=0, bits [15:12] are zero. Changing `fmt_twos` later does not alter words already stored.
- R4: The queue holds up to DEPTH words and returns them in the order they were stored.
- R5: On the edge after `rd_lo` is sampled, `rd_byte` shows bits [7:0] of the oldest word. On the edge after `rd_hi` is sampled, it shows bits [15:8], and that word is removed. A `rd_hi` while the queue is empty removes nothing. A read strobe must come at least two idle cycles after a high-byte read, a clear, or the rise of `data_avail`.
- R6: `data_avail` is 1 exactly when the queue holds at least one word.
- R7: A request that arrives while a conversion is in progress sets `overrun_flag` and starts nothing. The flag stays set until a clear.
- R8: A result that completes while the queue is full is discarded and sets `overflow_flag`. The flag stays set until a clear.
- R9: A `clear_wr` strobe leaves exactly one word in the queue. That word is the most recent captured result (including a discarded one), formed with the present `fmt_twos`. The strobe also clears both error flags and abandons a conversion in progress.
- R10: `err_irq` is high in the cycle after any cycle where `err_irq_en` is high and either error flag is set. It is low otherwise.
- R11: After reset, the queue is empty, both flags are clear, `adc_start`, `err_irq` and `rd_byte` are 0, and the stored last result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Software conversion request strobe |
| clear_wr | input | 1 | Clear strobe: reset queue and error flags |
| timer_out | input | 1 | Sample-timer output; a falling edge requests a conversion |
| ext_conv_n | input | 1 | External convert line; a falling edge requests a conversion |
| fmt_twos | input | 1 | 1: sign-extend results, 0: zero-pad results |
| err_irq_en | input | 1 | Enables the error interrupt |
| rd_lo | input | 1 | Host low-byte read strobe |
| rd_hi | input | 1 | Host high-byte read strobe (removes the word) |
| rd_byte | output | 8 | Registered read data byte |
| adc_start | output | 1 | One-cycle start pulse to the converter |
| adc_done | input | 1 | Converter result-ready strobe |
| adc_data | input | 12 | Converter result |
| data_avail | output | 1 | Queue holds at least one word |
| overflow_flag | output | 1 | Sticky: a result was lost to a full queue |
| overrun_flag | output | 1 | Sticky: a request arrived during a conversion |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench builds the block with DEPTH set to 8 instead of 512. This lets it fill the queue, push one result past capacity and drain it again in a few hundred cycles. It can therefore check the discarded ninth result, the sticky overflow flag and the wrap of both pointers. The converter's latency of 6 cycles leaves room to inject a second request in the middle of a conversion, which reaches the overrun path.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [0:0] {
    FMT_BINARY = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;
endpackage

// File: rtl/cfc_trig.sv
module cfc_trig #(
  parameter int N_EDGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_req,
  input  logic [N_EDGE-1:0] edge_in,
  output logic              trig
);
  logic [N_EDGE-1:0] fall;

  generate
    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
      logic prev;
      always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= edge_in[g];
      end
      assign fall[g] = prev & ~edge_in[g];
    end
  endgenerate

  assign trig = sw_req | (|fall);
endmodule

// File: rtl/cfc_seq.sv
module cfc_seq (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic trig,
  input  logic adc_done,
  output logic adc_start,
  output logic accept,
  output logic overrun
);
  logic busy;

  assign accept = adc_done & busy & ~clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      busy      <= 1'b0;
      adc_start <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      if (adc_done && busy) busy <= 1'b0;
      if (trig) begin
        if (busy) begin
          overrun <= 1'b1;
        end else begin
          adc_start <= 1'b1;
          busy      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfc_fifo.sv
module cfc_fifo
  import cfc_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int RAW_W  = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  fmt_e              fmt,
  input  logic              push,
  input  logic [RAW_W-1:0]  push_raw,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              not_empty,
  output logic              overflow
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = AW + 1;
  localparam int PAD = WORD_W - RAW_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic [RAW_W-1:0]  last_raw;

  logic              full, pop_ok, push_ok;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [RAW_W-1:0]  wr_raw;
  logic [WORD_W-1:0] wr_word;

  assign full    = (cnt == CW'(DEPTH));
  assign pop_ok  = pop & (cnt != '0);
  assign push_ok = push & ~full;

  // The clear strobe reloads slot 0 with the last captured result.
  assign wr_en   = clear | push_ok;
  assign wr_addr = clear ? '0 : wptr;
  assign wr_raw  = clear ? last_raw : push_raw;

  always_comb begin
    if (fmt == FMT_TWOS) wr_word = {{PAD{wr_raw[RAW_W-1]}}, wr_raw};
    else                 wr_word = {{PAD{1'b0}}, wr_raw};
  end

  // Simple dual-port storage with a registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
    head <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
      last_raw <= '0;
    end else if (clear) begin
      wptr     <= AW'(1);
      rptr     <= '0;
      cnt      <= CW'(1);
      overflow <= 1'b0;
    end else begin
      if (push) begin
        last_raw <= push_raw;
        if (full) overflow <= 1'b1;
      end
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign not_empty = (cnt != '0);
endmodule

// File: rtl/conv_fifo_ctrl.sv
module conv_fifo_ctrl
  import cfc_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int RAW_W  = 12,
  parameter int WORD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_wr,
  input  logic             clear_wr,
  input  logic             timer_out,
  input  logic             ext_conv_n,
  input  logic             fmt_twos,
  input  logic             err_irq_en,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [7:0]       rd_byte,
  output logic             adc_start,
  input  logic             adc_done,
  input  logic [RAW_W-1:0] adc_data,
  output logic             data_avail,
  output logic             overflow_flag,
  output logic             overrun_flag,
  output logic             err_irq
);
  localparam int N_EDGE = 2;

  logic              trig, accept;
  logic [WORD_W-1:0] head;

  cfc_trig #(.N_EDGE(N_EDGE)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .sw_req  (start_wr),
    .edge_in ({ext_conv_n, timer_out}),
    .trig    (trig)
  );

  cfc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear_wr),
    .trig      (trig),
    .adc_done  (adc_done),
    .adc_start (adc_start),
    .accept    (accept),
    .overrun   (overrun_flag)
  );

  cfc_fifo #(.DEPTH(DEPTH), .RAW_W(RAW_W), .WORD_W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear_wr),
    .fmt       (fmt_e'(fmt_twos)),
    .push      (accept),
    .push_raw  (adc_data),
    .pop       (rd_hi & ~clear_wr),
    .head      (head),
    .not_empty (data_avail),
    .overflow  (overflow_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte <= '0;
      err_irq <= 1'b0;
    end else begin
      if (rd_lo)      rd_byte <= head[BYTE_W-1:0];
      else if (rd_hi) rd_byte <= head[2*BYTE_W-1:BYTE_W];
      err_irq <= err_irq_en & (overflow_flag | overrun_flag);
    end
  end
endmodule

// File: rtl/conv_fifo_chk.sv
module conv_fifo_chk (
  input logic clk,
  input logic rst,
  input logic clear_wr,
  input logic adc_start,
  input logic data_avail,
  input logic overflow_flag,
  input logic overrun_flag,
  input logic err_irq_en,
  input logic err_irq
);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_flag && !clear_wr) |=> overrun_flag);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow_flag && !clear_wr) |=> overflow_flag);

  // R9
  clear_effect_chk: assert property (@(posedge clk) disable iff (rst)
    clear_wr |=> (data_avail && !overflow_flag && !overrun_flag));

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (err_irq_en && (overflow_flag || overrun_flag)) |=> err_irq);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!err_irq_en || !(overflow_flag || overrun_flag)) |=> !err_irq);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!data_avail && !overflow_flag && !overrun_flag && !adc_start && !err_irq));
endmodule

bind conv_fifo_ctrl conv_fifo_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .clear_wr      (clear_wr),
  .adc_start     (adc_start),
  .data_avail    (data_avail),
  .overflow_flag (overflow_flag),
  .overrun_flag  (overrun_flag),
  .err_irq_en    (err_irq_en),
  .err_irq       (err_irq)
);

// File: tb/conv_fifo_ctrl_test.sv
module conv_fifo_ctrl_test;
  localparam int DEPTH = 8;
  localparam int LAT   = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_wr = 0, clear_wr = 0, timer_out = 1, ext_conv_n = 1;
  logic        fmt_twos = 0, err_irq_en = 0, rd_lo = 0, rd_hi = 0;
  logic [7:0]  rd_byte;
  logic        adc_start, adc_done = 0;
  logic [11:0] adc_data = '0;
  logic        data_avail, overflow_flag, overrun_flag, err_irq;

  int checks = 0, errors = 0, n_starts = 0;
  bit done_flag = 0;
  logic [15:0] exp_q[$];
  logic [11:0] raw_q[$];

  always #10 clk = ~clk;

  conv_fifo_ctrl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .start_wr(start_wr), .clear_wr(clear_wr),
    .timer_out(timer_out), .ext_conv_n(ext_conv_n), .fmt_twos(fmt_twos),
    .err_irq_en(err_irq_en), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_byte(rd_byte),
    .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
    .data_avail(data_avail), .overflow_flag(overflow_flag),
    .overrun_flag(overrun_flag), .err_irq(err_irq)
  );

  function automatic logic [15:0] widen(logic [11:0] r, logic tw);
    return tw ? {{4{r[11]}}, r} : {4'h0, r};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Converter model: answers each start pulse after LAT cycles.
  always @(negedge clk) if (adc_start) n_starts++;
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        idle(LAT - 1);
        adc_data = raw_q.size() != 0 ? raw_q.pop_front() : 12'h000;
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
      end
    end
  end

  // Driver: queue the expected word, then request one conversion.
  task automatic convert(logic [11:0] raw, int src, bit keep);
    raw_q.push_back(raw);
    if (keep) exp_q.push_back(widen(raw, fmt_twos));
    case (src)
      0: begin start_wr = 1; @(negedge clk); start_wr = 0; end
      1: begin timer_out = 0; @(negedge clk); timer_out = 1; end
      default: begin ext_conv_n = 0; @(negedge clk); ext_conv_n = 1; end
    endcase
    idle(LAT + 4);
  endtask

  task automatic read_word(output logic [15:0] w);
    rd_lo = 1; @(negedge clk); rd_lo = 0;
    w[7:0] = rd_byte;
    rd_hi = 1; @(negedge clk); rd_hi = 0;
    w[15:8] = rd_byte;
    idle(2);
  endtask

  // Monitor side of the scoreboard: pop the oldest expected word and compare.
  task automatic take(string req);
    logic [15:0] w, e;
    read_word(w);
    e = exp_q.size() != 0 ? exp_q.pop_front() : 16'hxxxx;
    chk(w === e, req, w, e);
  endtask

  task automatic do_clear();
    clear_wr = 1; @(negedge clk); clear_wr = 0;
    idle(3);
  endtask

  initial begin
    logic [15:0] junk;
    int s0;
    idle(3);
    rst = 0;
    idle(1);
    // R11 reset state
    chk(data_avail == 0 && overflow_flag == 0 && overrun_flag == 0, "R11 status", {data_avail, overflow_flag, overrun_flag}, 0);
    chk(adc_start == 0 && err_irq == 0 && rd_byte == 0, "R11 outputs", {adc_start, err_irq, rd_byte}, 0);

    // R9 R11: clear after reset reloads the zero last value
    do_clear();
    chk(data_avail == 1, "R9 one word after clear", data_avail, 1);
    exp_q.push_back(16'h0000);
    take("R9 R11 reload of reset value");
    chk(data_avail == 0, "R6 empty after read", data_avail, 0);

    // R5: high-byte read on an empty queue moves nothing
    read_word(junk);
    chk(data_avail == 0, "R5 empty pop ignored", data_avail, 0);

    // R1 R3 software start, binary format
    s0 = n_starts;
    convert(12'h123, 0, 1);
    chk(n_starts == s0 + 1, "R2 one start pulse", n_starts, s0 + 1);
    chk(data_avail == 1, "R6 data available", data_avail, 1);
    take("R1 R3 R5 software start word");

    // R1 timer and external edges, R3 formats, R4 order
    s0 = n_starts;
    fmt_twos = 1;
    convert(12'h800, 1, 1);
    convert(12'h7FF, 2, 1);
    fmt_twos = 0;
    convert(12'hABC, 0, 1);
    chk(n_starts == s0 + 3, "R1 rising edges start nothing", n_starts, s0 + 3);
    fmt_twos = 1;
    take("R3 R4 timer word sign extended");
    take("R3 R4 external word");
    take("R3 format fixed at store");

    // R7 overrun and R10 interrupt
    err_irq_en = 1;
    s0 = n_starts;
    raw_q.push_back(12'h9A5);
    exp_q.push_back(widen(12'h9A5, 1));
    start_wr = 1; @(negedge clk); start_wr = 0;
    idle(2);
    start_wr = 1; @(negedge clk); start_wr = 0;
    idle(2);
    chk(overrun_flag == 1, "R7 overrun set", overrun_flag, 1);
    chk(err_irq == 1, "R10 irq on overrun", err_irq, 1);
    idle(LAT + 4);
    chk(n_starts == s0 + 1, "R7 second request ignored", n_starts, s0 + 1);
    take("R7 word of the single conversion");
    chk(overrun_flag == 1, "R7 overrun sticky", overrun_flag, 1);

    // R9 clear drops flags, reloads last result with present format
    fmt_twos = 0;
    do_clear();
    chk(overrun_flag == 0 && err_irq == 0, "R9 flags cleared", {overrun_flag, err_irq}, 0);
    exp_q.push_back(widen(12'h9A5, 0));
    take("R9 reload of last result");

    // R8 overflow, R4 full depth with pointer wrap
    err_irq_en = 0;
    for (int i = 0; i < DEPTH + 1; i++)
      convert(12'h100 + 12'(i * 17), i % 3, i < DEPTH);
    chk(overflow_flag == 1, "R8 overflow set", overflow_flag, 1);
    chk(err_irq == 0, "R10 irq masked", err_irq, 0);
    for (int i = 0; i < DEPTH; i++) take("R4 R8 drain order");
    chk(data_avail == 0, "R8 extra result discarded", data_avail, 0);
    chk(overflow_flag == 1, "R8 overflow sticky", overflow_flag, 1);
    err_irq_en = 1;
    idle(2);
    chk(err_irq == 1, "R10 irq on overflow", err_irq, 1);

    // R9 the discarded result is still the last captured value
    do_clear();
    chk(overflow_flag == 0, "R9 overflow cleared", overflow_flag, 0);
    exp_q.push_back(widen(12'h100 + 12'(DEPTH * 17), 0));
    take("R9 reload of discarded result");
    chk(data_avail == 0, "R6 empty at end", data_avail, 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule